// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block models the command decoder of a parallel NOR flash device, word mode. It watches host write cycles (address, data, one-cycle write strobe) and follows the two-cycle unlock handshake that comes before every multi-cycle command. From these writes it keeps track of the device mode. The modes are array read, identification, a pending program, a busy program, erase setup, a busy erase, erase suspend, and identification entered from inside erase suspend.

The read path reads the mode and the read address. While identification is active it returns a fixed manufacturer code, a fixed device code, or a per-sector protection flag taken from a parameter table. Otherwise it drives zero and lowers `rd_id`, which tells the array read path to supply the data. Program and erase are abstract busy states only. An external `op_done` pulse ends them; it has no effect while erase is suspended.

The unlock pair is 555h/AAh followed by 2AAh/55h. The command codes are 90h (identify), F0h (reset), A0h (program), 80h (erase setup), 30h (sector erase, and also resume), and B0h (suspend).

Top module: `nor_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset: `rd_id`=0, `rd_data`=00h, `busy`=0, `suspended`=0.
- R2: Identification mode starts only after the writes 555h/AAh, 2AAh/55h and then data 90h at any address. From the next cycle `rd_id`=1.
- R3: In identification mode, reads at offsets 00h, 04h, 08h and 0Ch return MFR_CODE (default 7Fh) and a read at offset 01h returns DEV_CODE (default A3h). Any other offset except 02h returns 00h. The offset is the address below the sector field. Reads repeat any number of times at any sector.
- R4: An identification read at offset 02h returns 01h when PROT_MAP bit [sector] is set and 00h otherwise. The sector is rd_addr[15:13]. The default PROT_MAP is 10000101b.
- R5: A write of F0h at any address ends identification mode. Outside identification `rd_id`=0 and `rd_data`=00h.
- R6: A write that breaks the unlock order drops the tracker back to its start. A 90h that follows a broken sequence does not start identification.
- R7: Unlock, A0h, then one data write sets `busy`=1. `busy` stays 0 until that data write. `op_done` returns to array read.
- R8: Unlock, 80h, unlock, 30h starts an erase (`busy`=1, `suspended`=0). `op_done` ends it and returns to array read.
- R9: B0h at any address during an erase gives `busy`=0, `suspended`=1. `op_done` has no effect while suspended.
- R10: 30h at any address while suspended resumes the erase. A further 30h during the erase is ignored. A new B0h suspends the erase again.
- R11: Unlock plus 90h while suspended enters identification with `suspended` still 1. The codes can be read inside the erasing sector. F0h returns to erase suspend, not to array read.
- R12: A broken unlock sequence during suspend leaves the block suspended. A broken sequence during erase setup returns it to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data of the write |
| rd_addr | input | ADDR_W | Address of the current read cycle |
| op_done | input | 1 | Program or erase finished |
| rd_id | output | 1 | Read returns identification data, not array data |
| rd_data | output | 8 | Identification read data, 00h when rd_id is 0 |
| busy | output | 1 | Program or erase running |
| suspended | output | 1 | Erase suspended (also while identifying from suspend) |

## Verification
The hardest state to reach is identification nested inside erase suspend. Reaching it takes a full six-write erase start, a suspend, and a second unlock sequence. The exit must then land back in suspend rather than in array read. The stimulus builds this chain step by step and checks the ports after each step. It reads the codes at an address inside the sector being erased. It also pulses `op_done` during the suspend to show the erase stays parked. A broken unlock is injected both inside suspend and inside erase setup, because the two states recover differently.

// File: rtl/nor_cmd_pkg.sv
// Package: command codes, unlock keys and mode encoding shared by the
// command decoder modules. Assumes word-mode addressing.
package nor_cmd_pkg;
    localparam logic [7:0] KEY1_DATA    = 8'hAA;
    localparam logic [7:0] KEY2_DATA    = 8'h55;
    localparam int unsigned KEY1_ADDR   = 'h555;
    localparam int unsigned KEY2_ADDR   = 'h2AA;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERA_SET  = 8'h80;
    localparam logic [7:0] CMD_ERA_GO   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESUME   = 8'h30;

    typedef enum logic [2:0] {
        ST_READ, ST_ID, ST_PGM_ARM, ST_PROG,
        ST_ERA_ARM, ST_ERASE, ST_SUSP, ST_ID_SUSP
    } mode_e;
endpackage

// File: rtl/nor_unlock_tracker.sv
// Unlock tracker: follows the two-write key sequence and flags the write
// that follows it as a command. Assumes one-cycle write strobes; the
// sequence is cleared whenever enable is low.
module nor_unlock_tracker
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              cmd_stb,
    output logic              stray,
    output logic              seq_idle
);
    localparam logic [1:0] STG_NONE = 2'd0;
    localparam logic [1:0] STG_ONE  = 2'd1;
    localparam logic [1:0] STG_CMD  = 2'd2;

    logic [1:0] stage;
    logic       hit1, hit2;

    // Key match decode for the current write.
    always_comb begin
        hit1 = (wr_addr == ADDR_W'(KEY1_ADDR)) && (wr_data == KEY1_DATA);
        hit2 = (wr_addr == ADDR_W'(KEY2_ADDR)) && (wr_data == KEY2_DATA);
    end

    assign cmd_stb  = enable && wr_en && (stage == STG_CMD);
    assign stray    = enable && wr_en &&
                      (((stage == STG_NONE) && !hit1) || ((stage == STG_ONE) && !hit2));
    assign seq_idle = (stage == STG_NONE);

    // Advance on matching keys, fall back to the start on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            stage <= STG_NONE;
        end else if (wr_en) begin
            case (stage)
                STG_NONE: stage <= hit1 ? STG_ONE : STG_NONE;
                STG_ONE:  stage <= hit2 ? STG_CMD : STG_NONE;
                default:  stage <= STG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/nor_mode_fsm.sv
// Mode state machine: moves between read, identification, program, erase
// and suspend on decoded commands and op_done. Assumes cmd_stb, stray and
// seq_idle come from the unlock tracker of the same write.
module nor_mode_fsm
    import nor_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cmd_stb,
    input  logic       stray,
    input  logic       seq_idle,
    input  logic       op_done,
    output mode_e      mode,
    output logic       trk_en
);
    mode_e nxt;

    // Tracker only listens in states that accept unlock sequences.
    assign trk_en = (mode == ST_READ) || (mode == ST_ID) || (mode == ST_ERA_ARM) ||
                    (mode == ST_SUSP) || (mode == ST_ID_SUSP);

    // Next-mode decode.
    always_comb begin
        nxt = mode;
        case (mode)
            ST_READ: if (cmd_stb) begin
                if (wr_data == CMD_IDENT)        nxt = ST_ID;
                else if (wr_data == CMD_PROGRAM) nxt = ST_PGM_ARM;
                else if (wr_data == CMD_ERA_SET) nxt = ST_ERA_ARM;
            end
            ST_ID:      if (wr_en && wr_data == CMD_RESET) nxt = ST_READ;
            ST_PGM_ARM: if (wr_en) nxt = ST_PROG;
            ST_PROG:    if (op_done) nxt = ST_READ;
            ST_ERA_ARM: begin
                if (cmd_stb) nxt = (wr_data == CMD_ERA_GO) ? ST_ERASE : ST_READ;
                else if (stray) nxt = ST_READ;
            end
            ST_ERASE: begin
                if (op_done) nxt = ST_READ;
                else if (wr_en && wr_data == CMD_SUSPEND) nxt = ST_SUSP;
            end
            ST_SUSP: begin
                if (cmd_stb && wr_data == CMD_IDENT) nxt = ST_ID_SUSP;
                else if (wr_en && seq_idle && wr_data == CMD_RESUME) nxt = ST_ERASE;
            end
            ST_ID_SUSP: if (wr_en && wr_data == CMD_RESET) nxt = ST_SUSP;
            default: nxt = ST_READ;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= ST_READ;
        else        mode <= nxt;
    end
endmodule

// File: rtl/nor_id_rom.sv
// Identification read table: fixed codes and per-sector protection flags.
// Assumes the sector number is the top SECT_W address bits.
module nor_id_rom #(
    parameter int                        ADDR_W   = 16,
    parameter int                        SECT_W   = 3,
    parameter logic [7:0]                MFR_CODE = 8'h7F,
    parameter logic [7:0]                DEV_CODE = 8'hA3,
    parameter logic [(1<<SECT_W)-1:0]    PROT_MAP = '0
) (
    input  logic              id_active,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int OFS_W  = ADDR_W - SECT_W;
    localparam int N_MFR  = 4;

    logic [SECT_W-1:0] sect;
    logic [OFS_W-1:0]  ofs;
    logic [N_MFR-1:0]  mfr_hit;

    assign sect = rd_addr[ADDR_W-1 -: SECT_W];
    assign ofs  = rd_addr[OFS_W-1:0];

    // One comparator per manufacturer-code alias offset (0h, 4h, 8h, Ch).
    for (genvar i = 0; i < N_MFR; i++) begin : g_mfr
        assign mfr_hit[i] = (ofs == OFS_W'(4 * i));
    end

    // Read data select.
    always_comb begin
        rd_data = 8'h00;
        if (id_active) begin
            if (|mfr_hit)                 rd_data = MFR_CODE;
            else if (ofs == OFS_W'(1))    rd_data = DEV_CODE;
            else if (ofs == OFS_W'(2))    rd_data = {7'd0, PROT_MAP[sect]};
        end
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
// Top: NOR flash command decoder. Combines the unlock tracker, the mode
// state machine and the identification table. Assumes single-cycle host
// write strobes and that op_done is pulsed by the array model.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int                     ADDR_W   = 16,
    parameter int                     SECT_W   = 3,
    parameter logic [7:0]             MFR_CODE = 8'h7F,
    parameter logic [7:0]             DEV_CODE = 8'hA3,
    parameter logic [(1<<SECT_W)-1:0] PROT_MAP = 8'b1000_0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              op_done,
    output logic              rd_id,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              suspended
);
    mode_e mode;
    logic  trk_en, cmd_stb, stray, seq_idle;

    nor_unlock_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .enable(trk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_stb(cmd_stb), .stray(stray), .seq_idle(seq_idle)
    );

    nor_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_stb(cmd_stb), .stray(stray), .seq_idle(seq_idle),
        .op_done(op_done), .mode(mode), .trk_en(trk_en)
    );

    // Port-level mode flags.
    assign rd_id     = (mode == ST_ID) || (mode == ST_ID_SUSP);
    assign busy      = (mode == ST_PROG) || (mode == ST_ERASE);
    assign suspended = (mode == ST_SUSP) || (mode == ST_ID_SUSP);

    nor_id_rom #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .MFR_CODE(MFR_CODE),
        .DEV_CODE(DEV_CODE), .PROT_MAP(PROT_MAP)
    ) u_rom (
        .id_active(rd_id), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
// Checker: port-level temporal properties of the command decoder.
module nor_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       op_done,
    input logic       rd_id,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       suspended
);
    p_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_id |-> rd_data == 8'h00);

    p_id_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && !suspended && wr_en && wr_data == 8'hF0 |=> !rd_id && !suspended);

    p_id_susp_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && suspended && wr_en && wr_data == 8'hF0 |=> !rd_id && suspended);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && suspended));

    p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && !rd_id && op_done && !wr_en |=> suspended);

    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !op_done && wr_en && wr_data == 8'h30 |=> busy);

    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && op_done |=> !busy && !suspended);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .rd_id(rd_id), .rd_data(rd_data),
    .busy(busy), .suspended(suspended)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic        op_done = 1'b0;
    logic        rd_id, busy, suspended;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int pending = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic        idv;
        logic [7:0]  dat;
        logic        bsy;
        logic        sus;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    nor_cmd_decoder u_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .op_done(op_done),
        .rd_id(rd_id), .rd_data(rd_data), .busy(busy), .suspended(suspended)
    );

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    // Driver side of the scoreboard: push one expectation, wait until compared.
    task automatic expect_rd(input logic [15:0] a, input logic i, input logic [7:0] d,
                             input logic b, input logic s, input string tag);
        exp_t e;
        e.addr = a; e.idv = i; e.dat = d; e.bsy = b; e.sus = s; e.tag = tag;
        q.push_back(e);
        pending++;
        wait (pending == 0);
        @(posedge clk);
    endtask

    // Monitor: pop an expectation, present its read address, compare outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                rd_addr = e.addr;
                #2;
                checks++;
                if (rd_id !== e.idv || rd_data !== e.dat || busy !== e.bsy || suspended !== e.sus) begin
                    errors++;
                    $display("FAIL %s addr=%h got id=%b data=%h busy=%b susp=%b exp id=%b data=%h busy=%b susp=%b",
                             e.tag, e.addr, rd_id, rd_data, busy, suspended, e.idv, e.dat, e.bsy, e.sus);
                end
                pending--;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, got running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R1 reset");

        // R2 / R3 / R4: identification entry and reads
        unlock();
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R2 unlock alone");
        wr(16'h0ABC, 8'h90);
        expect_rd(16'h0000, 1, 8'h7F, 0, 0, "R2 enter id");
        expect_rd(16'h0004, 1, 8'h7F, 0, 0, "R3 mfr 04");
        expect_rd(16'h0008, 1, 8'h7F, 0, 0, "R3 mfr 08");
        expect_rd(16'h600C, 1, 8'h7F, 0, 0, "R3 mfr 0C");
        expect_rd(16'h0001, 1, 8'hA3, 0, 0, "R3 dev");
        expect_rd(16'hA001, 1, 8'hA3, 0, 0, "R3 dev repeat");
        expect_rd(16'h0003, 1, 8'h00, 0, 0, "R3 other offset");
        expect_rd(16'hE002, 1, 8'h01, 0, 0, "R4 sector7 prot");
        expect_rd(16'h2002, 1, 8'h00, 0, 0, "R4 sector1 unprot");
        expect_rd(16'h4002, 1, 8'h01, 0, 0, "R4 sector2 prot");
        expect_rd(16'h0002, 1, 8'h01, 0, 0, "R4 sector0 prot");
        wr(16'h1234, 8'hF0);
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R5 reset exits id");

        // R6: broken unlock
        wr(16'h0555, 8'hAA);
        wr(16'h0123, 8'h77);
        wr(16'h02AA, 8'h55);
        wr(16'h0111, 8'h90);
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R6 broken seq no id");
        unlock(); wr(16'h0000, 8'h90);
        expect_rd(16'h0001, 1, 8'hA3, 0, 0, "R6 clean seq after break");
        wr(16'h0000, 8'hF0);

        // R7: program
        unlock(); wr(16'h0555, 8'hA0);
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R7 armed not busy");
        wr(16'h0100, 8'h12);
        expect_rd(16'h0000, 0, 8'h00, 1, 0, "R7 program busy");
        done_pulse();
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R7 program done");

        // R8: erase
        unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h4000, 8'h30);
        expect_rd(16'h0000, 0, 8'h00, 1, 0, "R8 erase busy");
        done_pulse();
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R8 erase done");

        // R12: broken sequence during erase setup
        unlock(); wr(16'h0555, 8'h80); wr(16'h0555, 8'h12);
        unlock(); wr(16'h4000, 8'h30);
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R12 setup aborted");

        // R9: suspend
        unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h4000, 8'h30);
        wr(16'h7777, 8'hB0);
        expect_rd(16'h0000, 0, 8'h00, 0, 1, "R9 suspended");
        done_pulse();
        expect_rd(16'h0000, 0, 8'h00, 0, 1, "R9 done ignored");

        // R11: identification from suspend
        unlock(); wr(16'h0000, 8'h90);
        expect_rd(16'h4004, 1, 8'h7F, 0, 1, "R11 mfr in erasing sector");
        expect_rd(16'h4001, 1, 8'hA3, 0, 1, "R11 dev in erasing sector");
        wr(16'h0000, 8'hF0);
        expect_rd(16'h0000, 0, 8'h00, 0, 1, "R11 back to suspend");

        // R12: broken sequence during suspend
        wr(16'h0555, 8'hAA); wr(16'h0100, 8'h99);
        expect_rd(16'h0000, 0, 8'h00, 0, 1, "R12 still suspended");

        // R10: resume, extra resume, resuspend
        wr(16'h3210, 8'h30);
        expect_rd(16'h0000, 0, 8'h00, 1, 0, "R10 resumed");
        wr(16'h0000, 8'h30);
        expect_rd(16'h0000, 0, 8'h00, 1, 0, "R10 extra resume ignored");
        wr(16'h0000, 8'hB0);
        expect_rd(16'h0000, 0, 8'h00, 0, 1, "R10 resuspend");
        wr(16'h0000, 8'h30);
        done_pulse();
        expect_rd(16'h0000, 0, 8'h00, 0, 0, "R10 erase completes");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule